// File: doc/BRIEF.md
# Interrupt Enable and Alarm Controller

This block holds a three-bit interrupt enable register and a single sticky interrupt flag for a disk controller. A function strobe writes the enable register. Each data bit that is high sets its enable bit. Each data bit that is low either clears its enable bit or leaves it alone, depending on a mode bit. Three events can set the interrupt flag, each gated by its own enable bit:
- the drive becoming ready and not busy, sampled across two controller phases;
- the end of an operation;
- an alarm.

Error conditions from the rest of the controller are gathered into an error latch. A two-stage alarm pipeline turns that latch into a one-cycle set-alarm pulse. The pulse sets a sticky alarm flag, asks the sequencer to end the operation, and can raise the interrupt. An output-function strobe clears the interrupt and alarm flags. The synchronous active-low reset acts as master clear and clears everything, including the enable register.

Top module: `irq_alarm_ctrl`

## Requirements
- R1: On a cycle with `fn_stb` high, each enable bit whose `fn_bits` bit is 1 becomes 1, whatever the mode. Bit positions are: 0 = ready-not-busy, 1 = end of operation, 2 = alarm.
- R2: On a cycle with `fn_stb` high and `fn_mode` high, each enable bit whose `fn_bits` bit is 0 becomes 0.
- R3: On a cycle with `fn_stb` high and `fn_mode` low, an enable bit whose data bit is 0 keeps its value. With `fn_stb` low, the whole enable register keeps its value.
- R4: While `rst_n` is low at a clock edge, the enable register, interrupt flag, alarm flag, error latch and alarm stages all become 0.
- R5: Ready-not-busy is `disk_rdy & on_cyl & !busy`. It is captured into a first stage on a cycle with `t1` high, and the first stage is copied into a second stage on a cycle with `t2` high. While the first stage is 1, the second is 0 and enable bit 0 is set, the interrupt flag is set at the next edge.
- R6: A ready-not-busy level that is never captured by `t1`, or a rise while enable bit 0 is clear, does not set the interrupt flag.
- R7: `eop_in` high while enable bit 1 is set sets the interrupt flag at the next edge. With enable bit 1 clear, it has no effect on the flag.
- R8: The error latch `err_pend` becomes 1 at the edge after any of these is high: `busy & !disk_rdy`, `ctl_seek_err`, `addr_err`, `drv_seek_err`, `end_sector & (parity_err | protect_flt)`, `end_sector & (ckwd_err | lost_data)`. Parity, protect, checkword and lost-data errors without `end_sector` do not set it.
- R9: One edge after `err_pend` rises, `eop_req` is high for exactly one cycle. At the edge that ends that cycle, `alarm` becomes 1.
- R10: The set-alarm pulse sets the interrupt flag in the same edge as `alarm` if enable bit 2 is set, and does not set it otherwise.
- R11: With no error cause still present, `err_pend` returns to 0 one edge after `alarm` is set, when the second alarm stage is seen high.
- R12: `oclr_stb` high clears `irq` and `alarm` at the next edge. A set event in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low master clear |
| t1 | input | 1 | Phase-1 strobe, one cycle wide |
| t2 | input | 1 | Phase-2 strobe, one cycle wide |
| fn_stb | input | 1 | Enable-register write strobe |
| fn_mode | input | 1 | 1: low data bits clear; 0: low data bits hold |
| fn_bits | input | 3 | Enable data bits (0 ready, 1 end of operation, 2 alarm) |
| oclr_stb | input | 1 | Output-function strobe clearing the flags |
| disk_rdy | input | 1 | Drive ready |
| on_cyl | input | 1 | Drive on cylinder |
| busy | input | 1 | Controller busy |
| ctl_seek_err | input | 1 | Controller seek error |
| addr_err | input | 1 | Address error |
| drv_seek_err | input | 1 | Drive seek error |
| end_sector | input | 1 | End of sector qualifier |
| parity_err | input | 1 | Storage parity error |
| protect_flt | input | 1 | Protect fault |
| ckwd_err | input | 1 | Checkword error |
| lost_data | input | 1 | Lost data |
| eop_in | input | 1 | End of operation event |
| int_en | output | 3 | Interrupt enable register |
| irq | output | 1 | Interrupt flag |
| alarm | output | 1 | Alarm flag |
| eop_req | output | 1 | One-cycle end-of-operation request from the alarm pipeline |
| err_pend | output | 1 | Error latch |

## Verification
The assertions assume that the phase strobes `t1` and `t2` are never high in the same cycle, and that `fn_stb` is a single-cycle pulse. The enable-hold property compares against the previous register value, so it is meaningful only under that pulse discipline. The stimulus drives each strobe for exactly one cycle between idle cycles, and never asserts `t1` together with `t2`. Error causes are held for one cycle and then released, so that the latch-clearing timing is visible at `err_pend`.

// File: rtl/irq_alarm_pkg.sv
// Package: shared widths and enable-bit positions for the interrupt/alarm block.
// Assumes: three interrupt sources in a fixed bit order.
package irq_alarm_pkg;
    localparam int EN_W    = 3;
    localparam int IDX_RNB = 0;
    localparam int IDX_EOP = 1;
    localparam int IDX_ALM = 2;
    localparam int N_CAUSE = 6;

    typedef logic [EN_W-1:0] en_vec_t;
endpackage

// File: rtl/irq_en_reg.sv
// Module: enable register with set / clear / hold update on a write strobe.
// A high data bit sets; a low data bit clears when mode is high, else holds.
// Assumes: ld is a single-cycle strobe; rst_n is synchronous master clear.
module irq_en_reg #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic         mode,
    input  logic [W-1:0] din,
    output logic [W-1:0] en_q
);
    logic [W-1:0] en_next;

    // Per-bit next value: set on one, clear-or-hold on zero.
    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            assign en_next[i] = din[i] | (~mode & en_q[i]);
        end
    endgenerate

    // Register update on strobe, cleared by master clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (ld)
            en_q <= en_next;
    end
endmodule

// File: rtl/rdy_edge_det.sv
// Module: two-phase sampler producing a rise window for a level.
// Stage 1 captures at phase 1, stage 2 copies stage 1 at phase 2.
// Assumes: ph1 and ph2 are never high in the same cycle.
module rdy_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic ph1,
    input  logic ph2,
    input  logic lvl,
    output logic rise
);
    logic s1_q;
    logic s2_q;

    // First stage: capture the level at phase 1.
    always_ff @(posedge clk) begin
        if (!rst_n)
            s1_q <= 1'b0;
        else if (ph1)
            s1_q <= lvl;
    end

    // Second stage: follow the first stage at phase 2.
    always_ff @(posedge clk) begin
        if (!rst_n)
            s2_q <= 1'b0;
        else if (ph2)
            s2_q <= s1_q;
    end

    assign rise = s1_q & ~s2_q;
endmodule

// File: rtl/alarm_pipe.sv
// Module: error latch followed by a two-stage alarm pipeline.
// Any cause sets the latch; stage 2 high clears it. Stage 1 and not
// stage 2 forms a one-cycle set pulse that sets a sticky alarm flag.
// Assumes: clr_flag is the output-function strobe; set beats clear.
module alarm_pipe #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] cause,
    input  logic         clr_flag,
    output logic         err_q,
    output logic         set_pulse,
    output logic         alarm_q
);
    logic st1_q;
    logic st2_q;

    // Error latch: set by any cause, released once stage 2 is high.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else
            err_q <= (|cause) | (err_q & ~st2_q);
    end

    // Alarm stages: shift the latch through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st1_q <= 1'b0;
            st2_q <= 1'b0;
        end else begin
            st1_q <= err_q;
            st2_q <= st1_q;
        end
    end

    assign set_pulse = st1_q & ~st2_q;

    // Sticky alarm flag: set pulse wins over the clear strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            alarm_q <= 1'b0;
        else if (set_pulse)
            alarm_q <= 1'b1;
        else if (clr_flag)
            alarm_q <= 1'b0;
    end
endmodule

// File: rtl/irq_alarm_ctrl.sv
// Top: interrupt enable register, three gated interrupt sources and the
// alarm pipeline. Produces a sticky interrupt flag.
// Assumes: t1/t2 are exclusive single-cycle phase strobes; rst_n is a
// synchronous active-low master clear.
module irq_alarm_ctrl
    import irq_alarm_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            t1,
    input  logic            t2,
    input  logic            fn_stb,
    input  logic            fn_mode,
    input  logic [EN_W-1:0] fn_bits,
    input  logic            oclr_stb,
    input  logic            disk_rdy,
    input  logic            on_cyl,
    input  logic            busy,
    input  logic            ctl_seek_err,
    input  logic            addr_err,
    input  logic            drv_seek_err,
    input  logic            end_sector,
    input  logic            parity_err,
    input  logic            protect_flt,
    input  logic            ckwd_err,
    input  logic            lost_data,
    input  logic            eop_in,
    output logic [EN_W-1:0] int_en,
    output logic            irq,
    output logic            alarm,
    output logic            eop_req,
    output logic            err_pend
);
    en_vec_t             en_q;
    logic                rnb_lvl;
    logic                rnb_rise;
    logic [N_CAUSE-1:0]  causes;
    logic                set_alarm;
    logic                irq_set;
    logic                irq_q;

    // Enable register.
    irq_en_reg #(.W(EN_W)) u_en (
        .clk   (clk),
        .rst_n (rst_n),
        .ld    (fn_stb),
        .mode  (fn_mode),
        .din   (fn_bits),
        .en_q  (en_q)
    );

    // Ready-and-not-busy level and its phase-sampled rise.
    assign rnb_lvl = disk_rdy & on_cyl & ~busy;

    rdy_edge_det u_rdy (
        .clk   (clk),
        .rst_n (rst_n),
        .ph1   (t1),
        .ph2   (t2),
        .lvl   (rnb_lvl),
        .rise  (rnb_rise)
    );

    // Error causes gathered into one vector.
    always_comb begin
        causes    = '0;
        causes[0] = busy & ~disk_rdy;
        causes[1] = ctl_seek_err;
        causes[2] = addr_err;
        causes[3] = drv_seek_err;
        causes[4] = end_sector & (parity_err | protect_flt);
        causes[5] = end_sector & (ckwd_err | lost_data);
    end

    alarm_pipe #(.N(N_CAUSE)) u_alm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cause     (causes),
        .clr_flag  (oclr_stb),
        .err_q     (err_pend),
        .set_pulse (set_alarm),
        .alarm_q   (alarm)
    );

    // Interrupt set term: each source gated by its enable bit.
    assign irq_set = (rnb_rise  & en_q[IDX_RNB])
                   | (eop_in    & en_q[IDX_EOP])
                   | (set_alarm & en_q[IDX_ALM]);

    // Sticky interrupt flag: set beats the output-function clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else if (irq_set)
            irq_q <= 1'b1;
        else if (oclr_stb)
            irq_q <= 1'b0;
    end

    assign int_en  = en_q;
    assign irq     = irq_q;
    assign eop_req = set_alarm;
endmodule

// File: rtl/irq_alarm_chk.sv
// Checker: clocked properties on the interrupt/alarm block, bound to the top.
// Assumes: fn_stb is a single-cycle pulse; t1 and t2 are exclusive.
module irq_alarm_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       fn_stb,
    input logic       fn_mode,
    input logic [2:0] fn_bits,
    input logic       oclr_stb,
    input logic       eop_in,
    input logic [2:0] int_en,
    input logic       irq,
    input logic       alarm,
    input logic       eop_req,
    input logic       err_pend
);
    AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        fn_stb |=> ((int_en & $past(fn_bits)) == $past(fn_bits))); // R1

    AST_EN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_stb && fn_mode) |=> ((int_en & ~$past(fn_bits)) == 3'b000)); // R2

    AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_stb && !fn_mode) |=> ((int_en & ~$past(fn_bits)) == ($past(int_en) & ~$past(fn_bits)))); // R3

    AST_EN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !fn_stb |=> $stable(int_en)); // R3

    AST_EOP_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (eop_in && int_en[1]) |=> irq); // R7

    AST_ALARM_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        eop_req |=> !eop_req); // R9

    AST_ALARM_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        eop_req |=> alarm); // R9

    AST_ALARM_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (eop_req && int_en[2]) |=> irq); // R10

    AST_PULSE_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eop_req) |-> $past(err_pend)); // R9

    AST_ALARM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (oclr_stb && !eop_req) |=> !alarm); // R12
endmodule

bind irq_alarm_ctrl irq_alarm_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fn_stb   (fn_stb),
    .fn_mode  (fn_mode),
    .fn_bits  (fn_bits),
    .oclr_stb (oclr_stb),
    .eop_in   (eop_in),
    .int_en   (int_en),
    .irq      (irq),
    .alarm    (alarm),
    .eop_req  (eop_req),
    .err_pend (err_pend)
);

// File: tb/tb_irq_alarm_ctrl.sv
module tb_irq_alarm_ctrl;
    localparam time CLK_PERIOD = 10ns;
    localparam int  N_VEC = 10;
    // Each entry: {mode, data[2:0], expected enable[2:0]}, applied in order from 000.
    localparam logic [6:0] VEC [N_VEC] = '{
        {1'b0, 3'b111, 3'b111},
        {1'b0, 3'b000, 3'b111},
        {1'b1, 3'b000, 3'b000},
        {1'b0, 3'b101, 3'b101},
        {1'b1, 3'b001, 3'b001},
        {1'b0, 3'b010, 3'b011},
        {1'b1, 3'b110, 3'b110},
        {1'b0, 3'b001, 3'b111},
        {1'b1, 3'b100, 3'b100},
        {1'b0, 3'b000, 3'b100}
    };

    logic clk = 1'b0;
    logic rst_n, t1, t2, fn_stb, fn_mode, oclr_stb;
    logic [2:0] fn_bits;
    logic disk_rdy, on_cyl, busy, ctl_seek_err, addr_err, drv_seek_err;
    logic end_sector, parity_err, protect_flt, ckwd_err, lost_data, eop_in;
    logic [2:0] int_en;
    logic irq, alarm, eop_req, err_pend;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_alarm_ctrl dut (
        .clk(clk), .rst_n(rst_n), .t1(t1), .t2(t2),
        .fn_stb(fn_stb), .fn_mode(fn_mode), .fn_bits(fn_bits),
        .oclr_stb(oclr_stb), .disk_rdy(disk_rdy), .on_cyl(on_cyl),
        .busy(busy), .ctl_seek_err(ctl_seek_err), .addr_err(addr_err),
        .drv_seek_err(drv_seek_err), .end_sector(end_sector),
        .parity_err(parity_err), .protect_flt(protect_flt),
        .ckwd_err(ckwd_err), .lost_data(lost_data), .eop_in(eop_in),
        .int_en(int_en), .irq(irq), .alarm(alarm), .eop_req(eop_req),
        .err_pend(err_pend)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr_en(input logic m, input logic [2:0] d);
        fn_stb = 1'b1; fn_mode = m; fn_bits = d;
        step();
        fn_stb = 1'b0; fn_mode = 1'b0; fn_bits = 3'b000;
    endtask

    task automatic clear_flags();
        oclr_stb = 1'b1;
        step();
        oclr_stb = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; t1 = 0; t2 = 0; fn_stb = 0; fn_mode = 0; fn_bits = 0;
        oclr_stb = 0; disk_rdy = 1; on_cyl = 1; busy = 0; ctl_seek_err = 0;
        addr_err = 0; drv_seek_err = 0; end_sector = 0; parity_err = 0;
        protect_flt = 0; ckwd_err = 0; lost_data = 0; eop_in = 0;
        step(); step();
        // R4: reset state
        chk("R4 reset int_en", {5'b0, int_en}, 8'h0);
        chk("R4 reset flags", {4'b0, irq, alarm, eop_req, err_pend}, 8'h0);
        rst_n = 1'b1;
        step();

        // R1 R2 R3: table of enable writes
        for (int i = 0; i < N_VEC; i++) begin
            wr_en(VEC[i][6], VEC[i][5:3]);
            chk($sformatf("R1/R2/R3 enable vector %0d", i), {5'b0, int_en}, {5'b0, VEC[i][2:0]});
        end

        // R3: no strobe leaves the register alone
        fn_mode = 1'b1; fn_bits = 3'b011;
        step();
        fn_mode = 1'b0; fn_bits = 3'b000;
        chk("R3 idle hold", {5'b0, int_en}, 8'h4);

        wr_en(1'b0, 3'b111);
        // R6: level present but never captured by t1
        step(); step(); step();
        chk("R6 no t1 no irq", {7'b0, irq}, 8'h0);
        // R5: capture at t1, irq one edge later
        t1 = 1'b1; step(); t1 = 1'b0;
        chk("R5 irq not yet", {7'b0, irq}, 8'h0);
        step();
        chk("R5 rnb rise irq", {7'b0, irq}, 8'h1);
        t2 = 1'b1; step(); t2 = 1'b0;
        clear_flags();
        chk("R12 irq cleared", {7'b0, irq}, 8'h0);

        // R6: rise with enable bit 0 clear
        wr_en(1'b1, 3'b110);
        on_cyl = 1'b0;
        t1 = 1'b1; step(); t1 = 1'b0;
        t2 = 1'b1; step(); t2 = 1'b0;
        on_cyl = 1'b1;
        t1 = 1'b1; step(); t1 = 1'b0;
        step();
        chk("R6 gated rise no irq", {7'b0, irq}, 8'h0);
        t2 = 1'b1; step(); t2 = 1'b0;

        // R7: end of operation
        eop_in = 1'b1; step(); eop_in = 1'b0;
        chk("R7 eop irq", {7'b0, irq}, 8'h1);
        clear_flags();
        wr_en(1'b1, 3'b100);
        eop_in = 1'b1; step(); eop_in = 1'b0;
        chk("R7 eop masked", {7'b0, irq}, 8'h0);

        // R8 R9 R10 R11: alarm sequence with alarm enable set
        ctl_seek_err = 1'b1; step(); ctl_seek_err = 1'b0;
        chk("R8 latch set", {6'b0, err_pend, eop_req}, 8'h2);
        step();
        chk("R9 pulse high", {6'b0, eop_req, alarm}, 8'h2);
        step();
        chk("R9 pulse one cycle, alarm set", {6'b0, eop_req, alarm}, 8'h1);
        chk("R10 alarm irq", {7'b0, irq}, 8'h1);
        chk("R11 latch still set", {7'b0, err_pend}, 8'h1);
        step();
        chk("R11 latch released", {7'b0, err_pend}, 8'h0);
        step(); step();
        clear_flags();
        chk("R12 alarm cleared", {6'b0, alarm, irq}, 8'h0);

        // R10: alarm with its enable clear
        wr_en(1'b1, 3'b000);
        addr_err = 1'b1; step(); addr_err = 1'b0;
        step(); step();
        chk("R10 alarm without irq", {6'b0, alarm, irq}, 8'h2);
        step(); step(); step();
        clear_flags();

        // R8: end-of-sector qualified causes
        parity_err = 1'b1; ckwd_err = 1'b1; step();
        chk("R8 unqualified ignored", {7'b0, err_pend}, 8'h0);
        end_sector = 1'b1; parity_err = 1'b0; step();
        end_sector = 1'b0; ckwd_err = 1'b0;
        chk("R8 checkword at sector end", {7'b0, err_pend}, 8'h1);
        repeat (5) step();
        clear_flags();
        chk("R8 settled", {6'b0, err_pend, alarm}, 8'h0);

        // R12: set beats clear in the same cycle
        busy = 1'b1; disk_rdy = 1'b0; step();
        busy = 1'b0; disk_rdy = 1'b1;
        chk("R8 busy not ready", {7'b0, err_pend}, 8'h1);
        step();
        oclr_stb = 1'b1; step(); oclr_stb = 1'b0;
        chk("R12 set wins", {7'b0, alarm}, 8'h1);
        clear_flags();
        chk("R12 later clear", {7'b0, alarm}, 8'h0);

        // R4: master clear from a loaded state
        wr_en(1'b0, 3'b111);
        eop_in = 1'b1; step(); eop_in = 1'b0;
        rst_n = 1'b0; step(); rst_n = 1'b1;
        chk("R4 master clear", {4'b0, int_en, irq}, 8'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule